// File: doc/BRIEF.md
# Display Processor Register Write Decoder

This block sits behind the control port of a tile-based video display processor. It turns the host's byte stream on that port into register updates. The host always sends bytes in pairs. The first byte is only held. The second byte says what to do with it. If the second byte has its top two bits at `10`, the held byte is written into the register whose number the rest of the second byte gives. If its top bit is `0`, the pair sets up the 14-bit memory address pointer. Any other second byte is a no-op. A read of the status port puts the pairing back to the first-byte position. Host software uses this to recover from an unknown phase.

A lockout flag chooses how the register number is decoded. With the lockout set, only the three lowest command bits are used. Older software that leaves stray ones in the upper bits still reaches the first eight registers, and the extended registers stay out of reach. With the lockout clear, the low six bits are decoded and all 64 registers can be written. The name-table base register keeps only its four meaningful bits. The register file can be read back through a combinational index port so that the consumers can see it.

Top module: `vdp_ctl_decoder`

## Requirements
- R1: After reset, every register reads 0, the lockout flag is 1, the address pointer is 0 and the port expects a first byte (`second_pending` = 0).
- R2: Each accepted control byte toggles `second_pending`. The first byte of a pair changes no register and does not change the pointer.
- R3: A second byte of the form `10xxxxxx` stores the held first byte into the selected register. The new value can be read back from the cycle after the write.
- R4: With the lockout set, the register number is bits 2:0 of the second byte, so `10001111` writes register 7.
- R5: With the lockout clear, the register number is bits 5:0 of the second byte, so `10001111` writes register 15 and `10111111` writes register 63.
- R6: With the lockout set, no register numbered 8 or above ever changes, whatever the second byte holds.
- R7: Register 2 (name-table base) keeps only its bits 3:0. Its bits 7:4 always read 0.
- R8: A second byte with bit 7 = 0 loads the pointer with {second[5:0], first} and writes no register.
- R9: A second byte of the form `11xxxxxx` writes no register, leaves the pointer unchanged and returns the port to first-byte phase.
- R10: A status read returns the port to first-byte phase. A control byte that arrives in the same cycle as a status read is discarded.
- R11: A `lock_wr` pulse loads the lockout flag from `lock_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port byte strobe |
| ctl_byte | input | 8 | Control-port byte |
| stat_rd | input | 1 | Status-port read strobe |
| lock_wr | input | 1 | Load the lockout flag |
| lock_val | input | 1 | New lockout value |
| rd_idx | input | 6 | Register readback index |
| rd_data | output | 8 | Register readback value |
| addr_ptr | output | 14 | Memory address pointer |
| second_pending | output | 1 | 1 while a first byte is held |
| locked | output | 1 | Lockout flag |

## Verification
The hardest case to reach is an ignored write under lockout. A command aimed at register 8 or above aliases onto a low register, and the extended register must keep the value it had. The stimulus first unlocks the block and writes a known value into register 8. It then locks the block and sends the same command byte. Finally it reads back both register 8 and the aliased register 0. Phase recovery is driven the same way: a status read is placed between the two bytes of a pair, and another in the same cycle as a byte.

// File: rtl/vdpc_pkg.sv
package vdpc_pkg;
   // Kind of action selected by the second byte of a pair
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_REG   = 2'd1,
      ACT_PTR   = 2'd2
   } vdpc_act_e;

   function automatic vdpc_act_e classify(input logic [7:0] b);
      if (!b[7])     return ACT_PTR;
      else if (!b[6]) return ACT_REG;
      else           return ACT_NONE;
   endfunction
endpackage

// File: rtl/vdpc_phase.sv
module vdpc_phase #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_byte,
   input  logic              stat_rd,
   output logic              phase,
   output logic [DATA_W-1:0] held,
   output logic              take_second
);
   logic accept;

   assign accept      = ctl_wr && !stat_rd;
   assign take_second = accept && phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= 1'b0;
         held  <= '0;
      end else if (stat_rd) begin
         phase <= 1'b0;
      end else if (accept) begin
         phase <= !phase;
         if (!phase) held <= ctl_byte;
      end
   end
endmodule

// File: rtl/vdpc_decode.sv
module vdpc_decode
   import vdpc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int IDX_W       = 6,
   parameter int COMPAT_BITS = 3,
   parameter int ADDR_W      = 14
) (
   input  logic              take_second,
   input  logic [DATA_W-1:0] held,
   input  logic [DATA_W-1:0] cmd,
   input  logic              locked,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              ptr_ld,
   output logic [ADDR_W-1:0] ptr_val
);
   localparam int HI_W = ADDR_W - DATA_W;

   vdpc_act_e act;
   logic [IDX_W-1:0] idx_full, idx_compat;

   assign act      = classify(cmd);
   assign idx_full = cmd[IDX_W-1:0];

   generate
      if (COMPAT_BITS < IDX_W) begin : g_trunc
         assign idx_compat = {{(IDX_W-COMPAT_BITS){1'b0}}, cmd[COMPAT_BITS-1:0]};
      end else begin : g_same
         assign idx_compat = idx_full;
      end
   endgenerate

   always_comb begin
      wr_en   = take_second && (act == ACT_REG);
      wr_idx  = locked ? idx_compat : idx_full;
      wr_data = held;
      ptr_ld  = take_second && (act == ACT_PTR);
      ptr_val = {cmd[HI_W-1:0], held};
   end
endmodule

// File: rtl/vdpc_regfile.sv
module vdpc_regfile #(
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 64,
   parameter int NAME_REG  = 2,
   parameter int NAME_BITS = 4,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] regs [REG_COUNT];

   generate
      for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
         localparam logic [DATA_W-1:0] KEEP =
            (i == NAME_REG) ? DATA_W'((1 << NAME_BITS) - 1) : {DATA_W{1'b1}};
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
               regs[i] <= wr_data & KEEP;
         end
      end
   endgenerate

   assign rd_data = regs[rd_idx];
endmodule

// File: rtl/vdp_ctl_decoder.sv
module vdp_ctl_decoder #(
   parameter int DATA_W      = 8,
   parameter int REG_COUNT   = 64,
   parameter int COMPAT_BITS = 3,
   parameter int ADDR_W      = 14,
   parameter int NAME_REG    = 2,
   parameter int NAME_BITS   = 4,
   localparam int IDX_W      = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_byte,
   input  logic              stat_rd,
   input  logic              lock_wr,
   input  logic              lock_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr_ptr,
   output logic              second_pending,
   output logic              locked
);
   generate
      if (COMPAT_BITS > IDX_W) begin : g_bad_compat
         $error("COMPAT_BITS exceeds register index width");
      end
      if (ADDR_W <= DATA_W || ADDR_W > 2*DATA_W - 2) begin : g_bad_addr
         $error("ADDR_W must fit in one byte plus the low bits of the second");
      end
      if (NAME_REG >= REG_COUNT || NAME_BITS > DATA_W) begin : g_bad_name
         $error("Name-table register settings out of range");
      end
   endgenerate

   logic [DATA_W-1:0] held;
   logic              take_second;
   logic              wr_en, ptr_ld;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] ptr_val;

   vdpc_phase #(.DATA_W(DATA_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
      .stat_rd(stat_rd), .phase(second_pending), .held(held),
      .take_second(take_second)
   );

   vdpc_decode #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .COMPAT_BITS(COMPAT_BITS), .ADDR_W(ADDR_W)
   ) u_decode (
      .take_second(take_second), .held(held), .cmd(ctl_byte), .locked(locked),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .ptr_ld(ptr_ld), .ptr_val(ptr_val)
   );

   vdpc_regfile #(
      .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
      .NAME_REG(NAME_REG), .NAME_BITS(NAME_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_ptr <= '0;
         locked   <= 1'b1;
      end else begin
         if (ptr_ld)  addr_ptr <= ptr_val;
         if (lock_wr) locked   <= lock_val;
      end
   end
endmodule

// File: rtl/vdpc_checker.sv
module vdpc_checker #(
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 6,
   parameter int ADDR_W    = 14,
   parameter int COMPAT_N  = 8,
   parameter int NAME_REG  = 2,
   parameter int NAME_BITS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic              stat_rd,
   input logic              lock_wr,
   input logic              lock_val,
   input logic              locked,
   input logic              second_pending,
   input logic              wr_en,
   input logic              ptr_ld,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [DATA_W-1:0] rd_data,
   input logic [ADDR_W-1:0] addr_ptr
);
   assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !stat_rd) |=> (second_pending != $past(second_pending)));

   assert_first_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !second_pending |-> !wr_en && !ptr_ld);

   assert_lock_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && locked) |-> (wr_idx < IDX_W'(COMPAT_N)));

   assert_name_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(NAME_REG)) |-> (rd_data[DATA_W-1:NAME_BITS] == '0));

   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(addr_ptr));

   assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, ptr_ld}));

   assert_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !second_pending);

   assert_lock_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_wr |=> (locked == $past(lock_val)));
endmodule

bind vdp_ctl_decoder vdpc_checker #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
   .COMPAT_N(1 << COMPAT_BITS), .NAME_REG(NAME_REG), .NAME_BITS(NAME_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stat_rd(stat_rd),
   .lock_wr(lock_wr), .lock_val(lock_val), .locked(locked),
   .second_pending(second_pending), .wr_en(wr_en), .ptr_ld(ptr_ld),
   .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_data(rd_data), .addr_ptr(addr_ptr)
);

// File: tb/tb_vdp_ctl_decoder.sv
module tb_vdp_ctl_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_byte = '0;
   logic       stat_rd = 1'b0;
   logic       lock_wr = 1'b0;
   logic       lock_val = 1'b0;
   logic [5:0] rd_idx = '0;
   logic [7:0] rd_data;
   logic [13:0] addr_ptr;
   logic       second_pending;
   logic       locked;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vdp_ctl_decoder dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
      .stat_rd(stat_rd), .lock_wr(lock_wr), .lock_val(lock_val),
      .rd_idx(rd_idx), .rd_data(rd_data), .addr_ptr(addr_ptr),
      .second_pending(second_pending), .locked(locked)
   );

   typedef struct packed {
      logic       lk;
      logic [7:0] b0;
      logic [7:0] b1;
      logic [5:0] idx;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h5A, 8'h81, 6'd1,  8'h5A},  // R3 locked reg1
      '{1'b1, 8'h33, 8'h8F, 6'd7,  8'h33},  // R4 0x8F -> reg7
      '{1'b1, 8'h77, 8'h8F, 6'd15, 8'h00},  // R6 reg15 untouched
      '{1'b0, 8'h44, 8'h8F, 6'd15, 8'h44},  // R5 0x8F -> reg15
      '{1'b0, 8'h99, 8'hBF, 6'd63, 8'h99},  // R5 0xBF -> reg63
      '{1'b0, 8'hF5, 8'h82, 6'd2,  8'h05},  // R7 name base masked
      '{1'b1, 8'hAB, 8'h82, 6'd2,  8'h0B},  // R7 locked
      '{1'b0, 8'h12, 8'h88, 6'd8,  8'h12},  // R5 reg8
      '{1'b1, 8'h66, 8'h88, 6'd0,  8'h66}   // R4 0x88 aliases reg0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_byte = b;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic pair(input logic [7:0] b0, input logic [7:0] b1);
      put_byte(b0);
      put_byte(b1);
   endtask

   task automatic set_lock(input logic v);
      @(negedge clk);
      lock_wr = 1'b1; lock_val = v;
      @(negedge clk);
      lock_wr = 1'b0;
   endtask

   task automatic status_read();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic read_reg(input logic [5:0] i, output logic [7:0] v);
      rd_idx = i;
      #1;
      v = rd_data;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 locked", locked, 1);
      check("R1 phase", second_pending, 0);
      check("R1 pointer", addr_ptr, 0);
      for (int i = 0; i < 64; i += 9) begin
         read_reg(6'(i), v);
         check("R1 reg", v, 0);
      end

      // Vector walk
      for (int k = 0; k < NV; k++) begin
         set_lock(VEC[k].lk);
         check("R11 lock flag", locked, VEC[k].lk);
         put_byte(VEC[k].b0);
         check("R2 phase after first", second_pending, 1);
         put_byte(VEC[k].b1);
         check("R2 phase after second", second_pending, 0);
         read_reg(VEC[k].idx, v);
         check("R3/R4/R5/R6/R7 vector readback", v, VEC[k].exp);
      end

      // R6: reg8 kept its value after the locked 0x88 write
      read_reg(6'd8, v);
      check("R6 reg8 untouched under lock", v, 8'h12);

      // R8 pointer setup, locked
      pair(8'h34, 8'h5A);
      check("R8 pointer", addr_ptr, 14'h1A34);
      read_reg(6'd2, v);
      check("R8 reg2 unchanged", v, 8'h0B);
      pair(8'h9E, 8'h40);
      check("R8 pointer bit6 ignored", addr_ptr, 14'h009E);

      // R9 11xxxxxx is a no-op
      pair(8'h77, 8'hC3);
      read_reg(6'd3, v);
      check("R9 reg3 unchanged", v, 8'h00);
      check("R9 pointer unchanged", addr_ptr, 14'h009E);
      check("R9 phase", second_pending, 0);

      // R10 status read between bytes
      put_byte(8'h22);
      check("R2 pending", second_pending, 1);
      status_read();
      check("R10 phase cleared", second_pending, 0);
      pair(8'h21, 8'h83);
      read_reg(6'd3, v);
      check("R10 resync write", v, 8'h21);

      // R10 simultaneous byte and status read
      @(negedge clk);
      ctl_wr = 1'b1; stat_rd = 1'b1; ctl_byte = 8'h55;
      @(negedge clk);
      ctl_wr = 1'b0; stat_rd = 1'b0;
      check("R10 simultaneous discarded", second_pending, 0);
      pair(8'h31, 8'h84);
      read_reg(6'd4, v);
      check("R10 following pair", v, 8'h31);

      done = 1'b1;
      finish_run();
   end
endmodule